// File: doc/BRIEF.md
# Instruction Decode Stage with Pending-Write Scoreboard

This block is the decode step of a small in-order pipeline. It takes one 32-bit instruction word in one of three layouts: register-register, register-immediate and jump. It works out the layout and opcode, picks out the register fields and the sign-extended immediate, and reads the needed source registers from a local register array. It hands three operand values, the destination index and a valid flag to the next stage one clock later.

Hazards are tracked with an ordered queue of destination registers whose results have not yet been written back. An instruction whose source is still in that queue is held back with `stall` until the writeback side pops the matching entry with `deq`. Destinations are reserved only when the instruction is accepted. `flush` empties the queue after a redirect. Stack instructions reach the stack-pointer register (index 2) without naming it, and the return instruction reads the link register (index 1).

Top module: `decode_scoreboard`

## Requirements
- R1: `in_word[1:0]` selects the layout (0 register, 1 immediate, 2 jump, 3 invalid). The opcode is `in_word[6:2]` for layout 0 and `in_word[5:2]` for layouts 1 and 2. Defined opcodes are 1..17 for layout 0, 1..11 for layout 1 and 1..10 for layout 2. `out_fmt` repeats the layout. `out_op` carries a defined opcode, or 0 (no operation: operands 0, no destination, no stall) for any other value.
- R2: Layout 0 takes source A from bits [10:7], source B from [14:11] and the destination from [18:15], giving x=reg[A], y=reg[B], z=0. Opcodes 16 and 17 (compares) reserve no destination.
- R3: Layout 1 has a low field [9:6], a high field [13:10] and an immediate [31:14] sign-extended into z. Opcodes 1–2 (loads) read the high field into x and reserve the low field. Opcodes 10–11 (stores) read low into x and high into y and reserve nothing. Opcodes 3–9 read low into x and reserve high. Layout 1 always gives y=0, except for stores.
- R4: Layout 2 has a register field [9:6] and an offset [31:10] sign-extended into y. Opcodes 1–7 read the field into x. Opcode 10 (return) reads register 1 into x instead.
- R5: Opcode 8 of layout 2 (push) gives x=-1, y=reg[field] and z=reg[2], and reserves register 2. Opcode 9 (pop) gives x=+1, y=0 and z=reg[2], and reserves the named register and then register 2. Both stall while register 2 is pending.
- R6: `stall` is high in the same cycle when `in_valid` is high and any source the instruction reads is pending. A stalled instruction reserves nothing. Register 0 is never reserved, so `out_dest_vld` is 0 for it.
- R7: The queue is first-in first-out. Each `deq` pulse frees the oldest reservation only. A `deq` on an empty queue has no effect.
- R8: The queue holds 8 entries. An instruction that needs more free entries than remain is stalled.
- R9: `flush` empties the queue in that cycle and stalls any instruction presented with it.
- R10: Layout 3 is never stalled. It reads nothing, reserves nothing, and is passed on with `out_op`=0 and operands 0.
- R11: After reset `out_valid` is 0, the queue is empty, and every register reads 0 except register 2, which reads 0x400.
- R12: A write through `rf_we` updates the register on the next edge. Writes to register 0 are ignored, and register 0 always reads 0.
- R13: `out_valid` is high for exactly the cycle after each accepted instruction. The other outputs keep their values until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 32 | Instruction word |
| stall | output | 1 | Instruction cannot be accepted this cycle |
| deq | input | 1 | Writeback retired the oldest reservation |
| flush | input | 1 | Clear all reservations |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 4 | Register write index |
| rf_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Decoded instruction available |
| out_fmt | output | 2 | Layout of the decoded instruction |
| out_op | output | 5 | Defined opcode or 0 |
| out_x | output | 32 | First operand |
| out_y | output | 32 | Second operand |
| out_z | output | 32 | Third operand |
| out_dest | output | 4 | Reserved destination index (0 if none) |
| out_dest_vld | output | 1 | A destination was reserved |

## Verification
`stall` is combinational and depends only on the current word and the queue contents. It is therefore read one time step after the inputs change at the falling edge, before any clock edge. The decoded fields, operands and `out_valid` are due on the first rising edge after acceptance. Queue changes from acceptance, `deq` and `flush` also take effect at that edge. The bench drives at a falling edge and reads decoded results at the next falling edge. Every stall probe is therefore taken against queue state that was settled one full edge earlier.

// File: rtl/dsb_pkg.sv
// Shared types for the decode stage: instruction layouts and operand-routing
// classes. Assumes a 32-bit instruction word with a 2-bit layout field.
package dsb_pkg;

    localparam int WORD_W   = 32;
    localparam int FMT_W    = 2;
    localparam int OPC_W    = 4;               // layouts 1 and 2; layout 0 uses one more
    localparam int OPC_R_W  = OPC_W + 1;
    localparam int OUT_OP_W = OPC_R_W;

    localparam int R_LAST      = 17;           // highest defined register-layout opcode
    localparam int R_CMP_FIRST = 16;           // compares reserve no destination
    localparam int I_LAST      = 11;
    localparam int I_LOAD_LAST = 2;
    localparam int I_STORE_1ST = 10;
    localparam int J_LAST      = 10;
    localparam int J_PUSH      = 8;
    localparam int J_POP       = 9;
    localparam int J_RET       = 10;

    typedef enum logic [FMT_W-1:0] {
        FMT_R   = 2'b00,
        FMT_I   = 2'b01,
        FMT_J   = 2'b10,
        FMT_BAD = 2'b11
    } fmt_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_RALU,
        K_RCMP,
        K_ILOAD,
        K_ISTORE,
        K_IALU,
        K_JPLAIN,
        K_JRET,
        K_JPUSH,
        K_JPOP
    } kind_e;

endpackage

// File: rtl/dsb_fields.sv
// Field extraction: splits an instruction word into layout, opcode, source
// and destination indices and the sign-extended immediate. Purely
// combinational. Assumes XLEN is at least as wide as the jump offset.
module dsb_fields
    import dsb_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int IDX_W    = 4,
    parameter int SP_IDX   = 2,
    parameter int LINK_IDX = 1
) (
    input  logic [WORD_W-1:0]   word,
    output logic [FMT_W-1:0]    fmt,
    output logic [OUT_OP_W-1:0] opc,
    output kind_e               kind,
    output logic [IDX_W-1:0]    src_a,
    output logic [IDX_W-1:0]    src_b,
    output logic                use_a,
    output logic                use_b,
    output logic [IDX_W-1:0]    dst_a,
    output logic [IDX_W-1:0]    dst_b,
    output logic                dst_a_v,
    output logic                dst_b_v,
    output logic [XLEN-1:0]     imm
);

    localparam int R_LO     = FMT_W + OPC_R_W;
    localparam int IJ_LO    = FMT_W + OPC_W;
    localparam int I_IMM_LO = IJ_LO + 2 * IDX_W;
    localparam int I_IMM_W  = WORD_W - I_IMM_LO;
    localparam int J_OFF_LO = IJ_LO + IDX_W;
    localparam int J_OFF_W  = WORD_W - J_OFF_LO;

    logic [OUT_OP_W-1:0] opc_r, opc_ij;
    logic [IDX_W-1:0]    r_a, r_b, r_d, i_lo, i_hi, j_r;
    logic [XLEN-1:0]     imm_i, imm_j;
    logic                want_a, want_b;

    // Slice all candidate fields for every layout
    always_comb begin
        opc_r  = word[FMT_W +: OPC_R_W];
        opc_ij = {1'b0, word[FMT_W +: OPC_W]};
        r_a    = word[R_LO +: IDX_W];
        r_b    = word[R_LO + IDX_W +: IDX_W];
        r_d    = word[R_LO + 2*IDX_W +: IDX_W];
        i_lo   = word[IJ_LO +: IDX_W];
        i_hi   = word[IJ_LO + IDX_W +: IDX_W];
        j_r    = word[IJ_LO +: IDX_W];
        imm_i  = {{(XLEN-I_IMM_W){word[WORD_W-1]}}, word[WORD_W-1:I_IMM_LO]};
        imm_j  = {{(XLEN-J_OFF_W){word[WORD_W-1]}}, word[WORD_W-1:J_OFF_LO]};
    end

    // Pick operand roles from layout and opcode
    always_comb begin
        fmt    = word[FMT_W-1:0];
        kind   = K_NONE;
        opc    = '0;
        src_a  = '0;
        src_b  = '0;
        use_a  = 1'b0;
        use_b  = 1'b0;
        dst_a  = '0;
        dst_b  = '0;
        want_a = 1'b0;
        want_b = 1'b0;
        imm    = '0;
        unique case (fmt_e'(word[FMT_W-1:0]))
            FMT_R: begin
                if (opc_r >= OUT_OP_W'(1) && opc_r <= OUT_OP_W'(R_LAST)) begin
                    opc   = opc_r;
                    src_a = r_a;
                    src_b = r_b;
                    use_a = 1'b1;
                    use_b = 1'b1;
                    if (opc_r >= OUT_OP_W'(R_CMP_FIRST)) begin
                        kind = K_RCMP;
                    end else begin
                        kind   = K_RALU;
                        dst_a  = r_d;
                        want_a = 1'b1;
                    end
                end
            end
            FMT_I: begin
                if (opc_ij >= OUT_OP_W'(1) && opc_ij <= OUT_OP_W'(I_LAST)) begin
                    opc   = opc_ij;
                    imm   = imm_i;
                    use_a = 1'b1;
                    if (opc_ij <= OUT_OP_W'(I_LOAD_LAST)) begin
                        kind   = K_ILOAD;
                        src_a  = i_hi;
                        dst_a  = i_lo;
                        want_a = 1'b1;
                    end else if (opc_ij >= OUT_OP_W'(I_STORE_1ST)) begin
                        kind  = K_ISTORE;
                        src_a = i_lo;
                        src_b = i_hi;
                        use_b = 1'b1;
                    end else begin
                        kind   = K_IALU;
                        src_a  = i_lo;
                        dst_a  = i_hi;
                        want_a = 1'b1;
                    end
                end
            end
            FMT_J: begin
                if (opc_ij >= OUT_OP_W'(1) && opc_ij <= OUT_OP_W'(J_LAST)) begin
                    opc = opc_ij;
                    imm = imm_j;
                    if (opc_ij == OUT_OP_W'(J_PUSH)) begin
                        kind   = K_JPUSH;
                        src_a  = j_r;
                        src_b  = IDX_W'(SP_IDX);
                        use_a  = 1'b1;
                        use_b  = 1'b1;
                        dst_a  = IDX_W'(SP_IDX);
                        want_a = 1'b1;
                    end else if (opc_ij == OUT_OP_W'(J_POP)) begin
                        kind   = K_JPOP;
                        src_b  = IDX_W'(SP_IDX);
                        use_b  = 1'b1;
                        dst_a  = j_r;
                        want_a = 1'b1;
                        dst_b  = IDX_W'(SP_IDX);
                        want_b = 1'b1;
                    end else if (opc_ij == OUT_OP_W'(J_RET)) begin
                        kind  = K_JRET;
                        src_a = IDX_W'(LINK_IDX);
                        use_a = 1'b1;
                    end else begin
                        kind  = K_JPLAIN;
                        src_a = j_r;
                        use_a = 1'b1;
                    end
                end
            end
            default: ;
        endcase
        // register 0 is never reserved
        dst_a_v = want_a && (dst_a != '0);
        dst_b_v = want_b && (dst_b != '0);
    end

endmodule

// File: rtl/dsb_regfile.sv
// Register array model: two combinational read ports and one write port.
// Register 0 is hard zero. The stack-pointer entry resets to SP_INIT.
// Assumes NREG equals 2**IDX_W.
module dsb_regfile #(
    parameter int              NREG    = 16,
    parameter int              XLEN    = 32,
    parameter int              IDX_W   = 4,
    parameter int              SP_IDX  = 2,
    parameter logic [XLEN-1:0] SP_INIT = 32'h0000_0400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [XLEN-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]  rdata_a,
    output logic [XLEN-1:0]  rdata_b
);

    logic [XLEN-1:0] regs [NREG];

    // Reset image and write port; index 0 never written
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                regs[r] <= (r == SP_IDX) ? SP_INIT : '0;
            end else if (we && waddr == IDX_W'(r) && r != 0) begin
                regs[r] <= wdata;
            end
        end
    end

    // Combinational read
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end

    // R12
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));

    // R12
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a == '0) |-> (rdata_a == '0));

endmodule

// File: rtl/dsb_pendq.sv
// Ordered queue of register indices that still await writeback. Up to two
// pushes per cycle (in order a then b), one pop of the oldest entry, and a
// flush. Reports whether each of two query indices is present.
// Assumes the caller never pushes more entries than free_slots allows.
module dsb_pendq #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pop,
    input  logic             push_a,
    input  logic [IDX_W-1:0] idx_a,
    input  logic             push_b,
    input  logic [IDX_W-1:0] idx_b,
    input  logic [IDX_W-1:0] q_a,
    input  logic [IDX_W-1:0] q_b,
    output logic             hit_a,
    output logic             hit_b,
    output logic [CNT_W-1:0] free_slots
);

    logic [IDX_W-1:0] ent [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] match_a, match_b;
    logic [PTR_W-1:0] head, tail, slot_b, tail_nx;
    logic [CNT_W-1:0] count;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Slot for the second push and the next tail
    always_comb begin
        do_pop  = pop && (count != '0);
        slot_b  = push_a ? nxt(tail) : tail;
        tail_nx = (push_a && push_b) ? nxt(nxt(tail)) :
                  (push_a || push_b) ? nxt(tail) : tail;
    end

    // Queue state update; flush behaves like reset
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld   <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (do_pop) begin
                vld[head] <= 1'b0;
                head      <= nxt(head);
            end
            if (push_a) begin
                ent[tail] <= idx_a;
                vld[tail] <= 1'b1;
            end
            if (push_b) begin
                ent[slot_b] <= idx_b;
                vld[slot_b] <= 1'b1;
            end
            tail  <= tail_nx;
            count <= count + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(do_pop);
        end
    end

    // Per-entry comparators for both queries
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match_a[i] = vld[i] && (ent[i] == q_a);
        assign match_b[i] = vld[i] && (ent[i] == q_b);
    end

    // Hit and room summary
    always_comb begin
        hit_a      = |match_a;
        hit_b      = |match_b;
        free_slots = CNT_W'(DEPTH) - count;
    end

    // R8
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld) == int'(count));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    // R8
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush) |-> (int'(push_a) + int'(push_b) <= int'(free_slots)));

endmodule

// File: rtl/decode_scoreboard.sv
// Decode stage top: field extraction, register read, pending-write queue and
// the registered output stage. Accepts a word when in_valid is high and no
// source is pending, enough queue room exists and no flush is present.
// Assumes NREG is a power of two.
module decode_scoreboard
    import dsb_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter int              NREG    = 16,
    parameter int              QDEPTH  = 8,
    parameter logic [XLEN-1:0] SP_INIT = 32'h0000_0400,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_word,
    output logic             stall,
    input  logic             deq,
    input  logic             flush,
    input  logic             rf_we,
    input  logic [IDX_W-1:0] rf_waddr,
    input  logic [XLEN-1:0]  rf_wdata,
    output logic             out_valid,
    output logic [1:0]       out_fmt,
    output logic [4:0]       out_op,
    output logic [XLEN-1:0]  out_x,
    output logic [XLEN-1:0]  out_y,
    output logic [XLEN-1:0]  out_z,
    output logic [IDX_W-1:0] out_dest,
    output logic             out_dest_vld
);

    localparam int SP_IDX   = 2;
    localparam int LINK_IDX = 1;
    localparam int CNT_W    = $clog2(QDEPTH + 1);

    logic [FMT_W-1:0]    d_fmt;
    logic [OUT_OP_W-1:0] d_opc;
    kind_e               d_kind;
    logic [IDX_W-1:0]    d_src_a, d_src_b, d_dst_a, d_dst_b;
    logic                d_use_a, d_use_b, d_dst_a_v, d_dst_b_v;
    logic [XLEN-1:0]     d_imm;
    logic [XLEN-1:0]     rd_a, rd_b;
    logic                hit_a, hit_b;
    logic [CNT_W-1:0]    free_slots;
    logic [CNT_W-1:0]    need;
    logic                hazard, accept;
    logic [XLEN-1:0]     nx_x, nx_y, nx_z;

    dsb_fields #(
        .XLEN    (XLEN),
        .IDX_W   (IDX_W),
        .SP_IDX  (SP_IDX),
        .LINK_IDX(LINK_IDX)
    ) u_fields (
        .word   (in_word),
        .fmt    (d_fmt),
        .opc    (d_opc),
        .kind   (d_kind),
        .src_a  (d_src_a),
        .src_b  (d_src_b),
        .use_a  (d_use_a),
        .use_b  (d_use_b),
        .dst_a  (d_dst_a),
        .dst_b  (d_dst_b),
        .dst_a_v(d_dst_a_v),
        .dst_b_v(d_dst_b_v),
        .imm    (d_imm)
    );

    dsb_regfile #(
        .NREG   (NREG),
        .XLEN   (XLEN),
        .IDX_W  (IDX_W),
        .SP_IDX (SP_IDX),
        .SP_INIT(SP_INIT)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr_a(d_src_a),
        .raddr_b(d_src_b),
        .rdata_a(rd_a),
        .rdata_b(rd_b)
    );

    dsb_pendq #(
        .DEPTH(QDEPTH),
        .IDX_W(IDX_W)
    ) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .pop       (deq),
        .push_a    (accept && d_dst_a_v),
        .idx_a     (d_dst_a),
        .push_b    (accept && d_dst_b_v),
        .idx_b     (d_dst_b),
        .q_a       (d_src_a),
        .q_b       (d_src_b),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .free_slots(free_slots)
    );

    // Hazard, room and acceptance decision
    always_comb begin
        need   = CNT_W'(d_dst_a_v) + CNT_W'(d_dst_b_v);
        hazard = (d_use_a && hit_a) || (d_use_b && hit_b);
        stall  = in_valid && (flush || hazard || (need > free_slots));
        accept = in_valid && !stall;
    end

    // Operand routing per instruction class
    always_comb begin
        nx_x = '0;
        nx_y = '0;
        nx_z = '0;
        unique case (d_kind)
            K_RALU, K_RCMP: begin
                nx_x = rd_a;
                nx_y = rd_b;
            end
            K_ISTORE: begin
                nx_x = rd_a;
                nx_y = rd_b;
                nx_z = d_imm;
            end
            K_ILOAD, K_IALU: begin
                nx_x = rd_a;
                nx_z = d_imm;
            end
            K_JPLAIN, K_JRET: begin
                nx_x = rd_a;
                nx_y = d_imm;
            end
            K_JPUSH: begin
                nx_x = '1;
                nx_y = rd_a;
                nx_z = rd_b;
            end
            K_JPOP: begin
                nx_x = XLEN'(1);
                nx_z = rd_b;
            end
            default: ;
        endcase
    end

    // Output register: loads on acceptance, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_fmt      <= '0;
            out_op       <= '0;
            out_x        <= '0;
            out_y        <= '0;
            out_z        <= '0;
            out_dest     <= '0;
            out_dest_vld <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_fmt      <= d_fmt;
                out_op       <= d_opc;
                out_x        <= nx_x;
                out_y        <= nx_y;
                out_z        <= nx_z;
                out_dest     <= d_dst_a_v ? d_dst_a : '0;
                out_dest_vld <= d_dst_a_v;
            end
        end
    end

    // R13
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !stall));

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(out_valid)) |-> $stable(out_x));

    // R9
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R10
    bad_fmt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && in_word[1:0] == 2'b11) |-> !stall);

    // R6
    stall_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> in_valid);

endmodule

// File: tb/tb_decode_scoreboard.sv
module tb_decode_scoreboard;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [4:0]  opc;
        logic [3:0]  a;
        logic [3:0]  b;
        logic [3:0]  c;
        logic [21:0] imm;
        logic [4:0]  eop;
        logic [31:0] ex;
        logic [31:0] ey;
        logic [31:0] ez;
        logic [3:0]  ed;
        logic        edv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    // Register contents during the table: reg[i] = 0x100 + i, reg[0] = 0
    localparam vec_t VECS [NV] = '{
        '{2'd0, 5'd1,  4'd3,  4'd4, 4'd5, 22'd0,       5'd1,  32'h103, 32'h104, 32'h0, 4'd5, 1'b1, 4'd2},         // R2 add
        '{2'd0, 5'd16, 4'd6,  4'd7, 4'd9, 22'd0,       5'd16, 32'h106, 32'h107, 32'h0, 4'd0, 1'b0, 4'd2},         // R2 compare
        '{2'd0, 5'd17, 4'd1,  4'd2, 4'd3, 22'd0,       5'd17, 32'h101, 32'h102, 32'h0, 4'd0, 1'b0, 4'd2},         // R2 compare 17
        '{2'd1, 5'd3,  4'd3,  4'd8, 4'd0, 22'h3FFFFB,  5'd3,  32'h103, 32'h0, 32'hFFFF_FFFB, 4'd8, 1'b1, 4'd3},   // R3 alu imm
        '{2'd1, 5'd1,  4'd8,  4'd3, 4'd0, 22'd20,      5'd1,  32'h103, 32'h0, 32'd20, 4'd8, 1'b1, 4'd3},          // R3 load swap
        '{2'd1, 5'd10, 4'd4,  4'd5, 4'd0, 22'h3FFFFF,  5'd10, 32'h104, 32'h105, 32'hFFFF_FFFF, 4'd0, 1'b0, 4'd3}, // R3 store
        '{2'd2, 5'd1,  4'd6,  4'd0, 4'd0, 22'h3FFF9C,  5'd1,  32'h106, 32'hFFFF_FF9C, 32'h0, 4'd0, 1'b0, 4'd4},   // R4 jump
        '{2'd2, 5'd10, 4'd7,  4'd0, 4'd0, 22'd3,       5'd10, 32'h101, 32'd3, 32'h0, 4'd0, 1'b0, 4'd4},           // R4 return
        '{2'd2, 5'd8,  4'd9,  4'd0, 4'd0, 22'd0,       5'd8,  32'hFFFF_FFFF, 32'h109, 32'h102, 4'd2, 1'b1, 4'd5},// R5 push
        '{2'd2, 5'd9,  4'd11, 4'd0, 4'd0, 22'd0,       5'd9,  32'd1, 32'h0, 32'h102, 4'd11, 1'b1, 4'd5},          // R5 pop
        '{2'd3, 5'd5,  4'd3,  4'd4, 4'd5, 22'd0,       5'd0,  32'h0, 32'h0, 32'h0, 4'd0, 1'b0, 4'd10},            // R10 bad layout
        '{2'd0, 5'd30, 4'd3,  4'd4, 4'd5, 22'd0,       5'd0,  32'h0, 32'h0, 32'h0, 4'd0, 1'b0, 4'd1},             // R1 undefined
        '{2'd2, 5'd15, 4'd3,  4'd0, 4'd0, 22'd7,       5'd0,  32'h0, 32'h0, 32'h0, 4'd0, 1'b0, 4'd1},             // R1 undefined
        '{2'd0, 5'd1,  4'd1,  4'd2, 4'd0, 22'd0,       5'd1,  32'h101, 32'h102, 32'h0, 4'd0, 1'b0, 4'd6},         // R6 dest r0
        '{2'd1, 5'd3,  4'd0,  4'd4, 4'd0, 22'd7,       5'd3,  32'h0, 32'h0, 32'd7, 4'd4, 1'b1, 4'd12},            // R12 r0 source
        '{2'd1, 5'd7,  4'd5,  4'd6, 4'd0, 22'h01FFFF,  5'd7,  32'h105, 32'h0, 32'h0001_FFFF, 4'd6, 1'b1, 4'd3},   // R3 max imm
        '{2'd1, 5'd4,  4'd5,  4'd6, 4'd0, 22'h020000,  5'd4,  32'h105, 32'h0, 32'hFFFE_0000, 4'd6, 1'b1, 4'd3},   // R3 min imm
        '{2'd2, 5'd4,  4'd3,  4'd0, 4'd0, 22'h200000,  5'd4,  32'h103, 32'hFFE0_0000, 32'h0, 4'd0, 1'b0, 4'd4}    // R4 min offset
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_word;
    logic        stall;
    logic        deq;
    logic        flush;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        out_valid;
    logic [1:0]  out_fmt;
    logic [4:0]  out_op;
    logic [31:0] out_x, out_y, out_z;
    logic [3:0]  out_dest;
    logic        out_dest_vld;

    int n_chk = 0;
    int n_bad = 0;

    decode_scoreboard dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .stall       (stall),
        .deq         (deq),
        .flush       (flush),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .out_valid   (out_valid),
        .out_fmt     (out_fmt),
        .out_op      (out_op),
        .out_x       (out_x),
        .out_y       (out_y),
        .out_z       (out_z),
        .out_dest    (out_dest),
        .out_dest_vld(out_dest_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R13: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] op, input logic [3:0] a, b, d);
        return {13'b0, d, b, a, op, 2'b00};
    endfunction
    function automatic logic [31:0] enc_i(input logic [3:0] op, input logic [3:0] lo, hi, input logic [17:0] imm);
        return {imm, hi, lo, op, 2'b01};
    endfunction
    function automatic logic [31:0] enc_j(input logic [3:0] op, input logic [3:0] r, input logic [21:0] off);
        return {off, r, op, 2'b10};
    endfunction

    function automatic logic [31:0] build(input vec_t v);
        case (v.fmt)
            2'd1:    return enc_i(v.opc[3:0], v.a, v.b, v.imm[17:0]);
            2'd2:    return enc_j(v.opc[3:0], v.a, v.imm);
            2'd3:    return {13'b0, v.c, v.b, v.a, v.opc, 2'b11};
            default: return enc_r(v.opc, v.a, v.b, v.c);
        endcase
    endfunction

    // Present a word for one cycle; returns stall seen before the edge.
    task automatic issue(input logic [31:0] w, output logic st);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        st = stall;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic do_deq();
        deq = 1'b1;
        @(negedge clk);
        deq = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [31:0] val);
        rf_we    = 1'b1;
        rf_waddr = idx;
        rf_wdata = val;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    initial begin
        logic st;
        logic [31:0] held;
        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; deq = 1'b0; flush = 1'b0;
        rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R11 stall idle", {31'b0, stall}, 32'd0);
        // R11 stack pointer reset value, seen through a push of r0
        issue(enc_j(4'd8, 4'd0, 22'd0), st);
        chk("R11 push no stall", {31'b0, st}, 32'd0);
        chk("R11 sp value", out_z, 32'h400);
        chk("R11 push y r0", out_y, 32'h0);
        do_flush();

        // R12 load registers, r0 write must be ignored
        for (int i = 1; i < 16; i++) wr_reg(4'(i), 32'h100 + i);
        wr_reg(4'd0, 32'hDEAD_BEEF);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
            issue(build(VECS[k]), st);
            chk({tag, " stall"}, {31'b0, st}, 32'd0);
            chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
            chk({tag, " fmt"}, {30'b0, out_fmt}, {30'b0, VECS[k].fmt});
            chk({tag, " op"}, {27'b0, out_op}, {27'b0, VECS[k].eop});
            chk({tag, " x"}, out_x, VECS[k].ex);
            chk({tag, " y"}, out_y, VECS[k].ey);
            chk({tag, " z"}, out_z, VECS[k].ez);
            chk({tag, " dest"}, {28'b0, out_dest}, {28'b0, VECS[k].ed});
            chk({tag, " dest_vld"}, {31'b0, out_dest_vld}, {31'b0, VECS[k].edv});
            do_flush();
        end

        // R13 outputs hold when nothing accepted
        issue(enc_r(5'd1, 4'd3, 4'd4, 4'd0), st);
        held = out_x;
        @(negedge clk);
        chk("R13 valid drops", {31'b0, out_valid}, 32'd0);
        chk("R13 x held", out_x, held);

        // R6 hazard on pending destination
        issue(enc_i(4'd3, 4'd3, 4'd8, 18'd1), st);
        chk("R6 producer accepted", {31'b0, st}, 32'd0);
        issue(enc_r(5'd1, 4'd8, 4'd4, 4'd0), st);
        chk("R6 consumer stalls", {31'b0, st}, 32'd1);
        chk("R6 no output when stalled", {31'b0, out_valid}, 32'd0);
        issue(enc_r(5'd1, 4'd3, 4'd4, 4'd0), st);
        chk("R6 independent no stall", {31'b0, st}, 32'd0);
        issue(enc_r(5'd1, 4'd0, 4'd0, 4'd0), st);
        chk("R6 r0 never pending", {31'b0, st}, 32'd0);
        issue(enc_r(5'd16, 4'd0, 4'd3, 4'd0), st);
        chk("R6 r0 dest not reserved", {31'b0, st}, 32'd0);
        do_deq();
        issue(enc_r(5'd16, 4'd8, 4'd4, 4'd0), st);
        chk("R7 freed after deq", {31'b0, st}, 32'd0);
        do_deq();
        do_deq();
        issue(enc_r(5'd16, 4'd8, 4'd4, 4'd0), st);
        chk("R7 deq on empty harmless", {31'b0, st}, 32'd0);
        do_flush();

        // R7 oldest first
        issue(enc_i(4'd3, 4'd0, 4'd5, 18'd0), st);
        issue(enc_i(4'd3, 4'd0, 4'd6, 18'd0), st);
        do_deq();
        issue(enc_r(5'd16, 4'd5, 4'd0, 4'd0), st);
        chk("R7 oldest freed", {31'b0, st}, 32'd0);
        issue(enc_r(5'd16, 4'd6, 4'd0, 4'd0), st);
        chk("R7 younger still pending", {31'b0, st}, 32'd1);
        do_flush();

        // R5 pop reserves named then stack pointer
        issue(enc_j(4'd9, 4'd11, 22'd0), st);
        chk("R5 pop accepted", {31'b0, st}, 32'd0);
        issue(enc_j(4'd8, 4'd3, 22'd0), st);
        chk("R5 push waits on sp", {31'b0, st}, 32'd1);
        do_deq();
        issue(enc_r(5'd16, 4'd11, 4'd0, 4'd0), st);
        chk("R7 pop named freed first", {31'b0, st}, 32'd0);
        issue(enc_j(4'd8, 4'd3, 22'd0), st);
        chk("R5 sp still pending", {31'b0, st}, 32'd1);
        do_deq();
        issue(enc_j(4'd8, 4'd3, 22'd0), st);
        chk("R5 push after sp free", {31'b0, st}, 32'd0);
        issue(enc_j(4'd1, 4'd2, 22'd0), st);
        chk("R5 push reserved sp", {31'b0, st}, 32'd1);
        do_flush();

        // R8 capacity
        for (int i = 0; i < 8; i++) begin
            issue(enc_i(4'd3, 4'd0, 4'(3 + i), 18'd0), st);
            chk("R8 fill accepted", {31'b0, st}, 32'd0);
        end
        issue(enc_i(4'd3, 4'd0, 4'd11, 18'd0), st);
        chk("R8 full stalls", {31'b0, st}, 32'd1);
        issue(enc_r(5'd16, 4'd12, 4'd13, 4'd0), st);
        chk("R8 no-dest passes when full", {31'b0, st}, 32'd0);
        do_flush();
        for (int i = 0; i < 7; i++) issue(enc_i(4'd3, 4'd0, 4'(3 + i), 18'd0), st);
        issue(enc_j(4'd9, 4'd12, 22'd0), st);
        chk("R8 pop needs two slots", {31'b0, st}, 32'd1);
        issue(enc_i(4'd3, 4'd0, 4'd12, 18'd0), st);
        chk("R8 last slot usable", {31'b0, st}, 32'd0);

        // R9 flush clears and blocks
        flush = 1'b1;
        in_valid = 1'b1;
        in_word = enc_r(5'd1, 4'd13, 4'd14, 4'd15);
        #1;
        chk("R9 stall with flush", {31'b0, stall}, 32'd1);
        @(negedge clk);
        flush = 1'b0;
        in_valid = 1'b0;
        chk("R9 nothing accepted", {31'b0, out_valid}, 32'd0);
        issue(enc_r(5'd1, 4'd3, 4'd4, 4'd0), st);
        chk("R9 queue empty after flush", {31'b0, st}, 32'd0);

        // R10 bad layout passes while registers pending
        issue(enc_i(4'd3, 4'd0, 4'd8, 18'd0), st);
        issue({13'b0, 4'd8, 4'd8, 4'd8, 5'd1, 2'b11}, st);
        chk("R10 no stall", {31'b0, st}, 32'd0);
        chk("R10 valid", {31'b0, out_valid}, 32'd1);
        chk("R10 op zero", {27'b0, out_op}, 32'd0);
        chk("R10 x zero", out_x, 32'd0);
        do_flush();

        // R12 write then read, r0 still zero
        wr_reg(4'd12, 32'h1234_5678);
        issue(enc_r(5'd16, 4'd12, 4'd0, 4'd0), st);
        chk("R12 written value", out_x, 32'h1234_5678);
        chk("R12 r0 reads zero", out_y, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule